// File: doc/BRIEF.md
# Triggered ADC Scan Sequencer

This block controls a multichannel analog-to-digital converter that times itself. A host loads a channel request mask and a temperature-enable bit through a small register port. It then pulses the conversion-start input low. When that input rises after a long enough low phase, the sequencer starts one scan with no further help from the host. It powers the converter up and waits a programmable wake-up time. It then runs acquisition and conversion for each requested item in turn, writes each tagged result into a result queue, and powers the converter down.

At the end of the scan the active-low end-of-conversion output drops. It stays low until the host asserts chip-select or pulls conversion-start low again. The converter is modelled as a one-cycle start strobe and a done strobe that comes back with a 12-bit value. The host reads results through a first-word-fall-through pop port.

A start request made while a scan is running does not restart or disturb that scan. It sets a sticky overrun flag instead. The overrun-clear register accepts writes at any time. The mask and temperature registers accept writes only while the sequencer is idle.

Top module: `scan_sequencer`

## Requirements
- R1: A scan is triggered only when `cnvst_n` rises after it was sampled low on at least `MIN_LOW` consecutive clock edges. A shorter low phase starts nothing: `busy` stays 0 and no result is queued.
- R2: After a trigger, `adc_pwr` and `busy` are 1 for the whole scan and 0 once it ends. The first `adc_start` strobe comes exactly `WAKE_CYC + ACQ_CYC` cycles after the trigger edge. Each strobe lasts one cycle.
- R3: Every channel whose bit is set in the mask (register address 0, bit i = channel i) is converted once, in ascending index order. Each queued entry is `{id[3:0], value[11:0]}`, where id is the channel index and value is the converter data returned for that conversion.
- R4: When temperature is enabled (register address 1, bit 0), its result is queued before every channel result of the same scan and carries id 15.
- R5: `eoc_n` goes low in the cycle after the last result of a scan is queued. Popping results does not raise it. It returns high on the clock edge after `cs_n` or `cnvst_n` is sampled low.
- R6: A valid start request during a scan is ignored and sets `overrun` to 1. Any write to register address 2 clears `overrun`, and this write is accepted while a scan is running.
- R7: Writes to register addresses 0 and 1 while `busy` is 1 have no effect. The scan in progress and the next scan both use the previous settings.
- R8: After reset, `eoc_n`=1, `busy`=0, `adc_pwr`=0, `overrun`=0, `fifo_empty`=1 and `fifo_count`=0.
- R9: `fifo_rd_data` shows the oldest entry whenever `fifo_empty` is 0. A pop while the queue is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnvst_n | input | 1 | Active-low conversion start request |
| cs_n | input | 1 | Active-low host chip-select, clears end-of-conversion |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mask, 1 temperature enable, 2 overrun clear |
| reg_wdata | input | NUM_CH | Register write data |
| adc_start | output | 1 | One-cycle converter start strobe |
| adc_chan | output | 4 | Item being converted (15 = temperature) |
| adc_pwr | output | 1 | Converter power-up request |
| adc_done | input | 1 | Converter result valid strobe |
| adc_data | input | 12 | Converter result |
| busy | output | 1 | Scan in progress |
| eoc_n | output | 1 | Active-low end-of-conversion flag |
| overrun | output | 1 | Sticky flag for a start request during a scan |
| pop | input | 1 | Remove the oldest queued result |
| fifo_rd_data | output | 16 | Oldest queued result `{id, value}` |
| fifo_empty | output | 1 | Result queue empty |
| fifo_count | output | CNT_W | Number of queued results |

## Verification
A corrupted pending mask or current-item register would show up at the ports as a missing, repeated or misordered id in the drained queue, and the host sees it as soon as it reads that scan's results. A wrong phase counter shifts the first `adc_start` away from its fixed offset after the trigger, so the error appears within one scan's wake-up and acquisition window. A stuck end-of-conversion or overrun state would be visible on `eoc_n` or `overrun` on the edge after the `cs_n`, `cnvst_n` or register write that should have changed it.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAKE,
    SQ_ACQ,
    SQ_CONV
  } seq_state_t;

  localparam int RES_W = 12;
  localparam int ID_W  = 4;
  localparam logic [ID_W-1:0] TEMP_ID = 4'hF;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [RES_W-1:0] value;
  } result_t;
endpackage

// File: rtl/start_detect.sv
module start_detect #(
  parameter int MIN_LOW = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnvst_n,
  output logic trig
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW);

  logic [CW-1:0] low_cnt_q, low_cnt_d;

  always_comb begin
    if (!cnvst_n) low_cnt_d = (low_cnt_q == LIM) ? low_cnt_q : low_cnt_q + 1'b1;
    else          low_cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt_q <= '0;
    else        low_cnt_q <= low_cnt_d;
  end

  assign trig = cnvst_n && (low_cnt_q == LIM);

  // R1
  trig_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(!cnvst_n));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int WAKE_CYC = 4,
  parameter int ACQ_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [NUM_CH-1:0] mask,
  input  logic              temp_en,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_data,
  output logic              adc_start,
  output logic [ID_W-1:0]   adc_chan,
  output logic              busy,
  output logic              push,
  output result_t           push_data,
  output logic              scan_done
);
  localparam int MAXC = (WAKE_CYC > ACQ_CYC) ? WAKE_CYC : ACQ_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WAKE_LD = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] ACQ_LD  = CW'(ACQ_CYC - 1);

  seq_state_t        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic              ptemp_q, ptemp_d;
  logic [ID_W-1:0]   cur_q, cur_d;
  logic              advance, any_pend;
  logic [ID_W-1:0]   nxt_id;

  // pick next item: temperature first, then lowest channel index
  always_comb begin
    any_pend = ptemp_q || (|pend_q);
    nxt_id   = TEMP_ID;
    if (!ptemp_q) begin
      nxt_id = '0;
      for (int i = NUM_CH - 1; i >= 0; i--)
        if (pend_q[i]) nxt_id = ID_W'(i);
    end
  end

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    pend_d    = pend_q;
    ptemp_d   = ptemp_q;
    cur_d     = cur_q;
    advance   = 1'b0;
    push      = 1'b0;
    scan_done = 1'b0;
    case (state_q)
      SQ_IDLE: if (trig) begin
        state_d = SQ_WAKE;
        cnt_d   = WAKE_LD;
        pend_d  = mask;
        ptemp_d = temp_en;
      end
      SQ_WAKE: begin
        if (cnt_q == '0) advance = 1'b1;
        else             cnt_d   = cnt_q - 1'b1;
      end
      SQ_ACQ: begin
        if (cnt_q == '0) state_d = SQ_CONV;
        else             cnt_d   = cnt_q - 1'b1;
      end
      SQ_CONV: if (adc_done) begin
        push    = 1'b1;
        advance = 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase
    if (advance) begin
      if (any_pend) begin
        state_d = SQ_ACQ;
        cnt_d   = ACQ_LD;
        cur_d   = nxt_id;
        if (ptemp_q) ptemp_d = 1'b0;
        else
          for (int i = 0; i < NUM_CH; i++)
            if (nxt_id == ID_W'(i)) pend_d[i] = 1'b0;
      end else begin
        state_d   = SQ_IDLE;
        scan_done = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      pend_q  <= '0;
      ptemp_q <= 1'b0;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      ptemp_q <= ptemp_d;
      cur_q   <= cur_d;
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  assign adc_start = (state_q == SQ_ACQ) && (cnt_q == '0);
  assign adc_chan  = cur_q;
  assign push_data = '{id: cur_q, value: adc_data};

  // R2
  start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
endmodule

// File: rtl/result_fifo.sv
module result_fifo #(
  parameter int DEPTH = 9,
  parameter int W     = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     rd_data,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push && (cnt_q != FULL);
  assign do_pop  = pop && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      if (do_push != do_pop) cnt_q <= do_push ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= push_data;
  end

  assign rd_data = mem[rptr_q];
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != FULL));
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int MIN_LOW  = 5,
  parameter int WAKE_CYC = 4,
  parameter int ACQ_CYC  = 3,
  localparam int CNT_W   = $clog2(NUM_CH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnvst_n,
  input  logic              cs_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [NUM_CH-1:0] reg_wdata,
  output logic              adc_start,
  output logic [3:0]        adc_chan,
  output logic              adc_pwr,
  input  logic              adc_done,
  input  logic [11:0]       adc_data,
  output logic              busy,
  output logic              eoc_n,
  output logic              overrun,
  input  logic              pop,
  output logic [15:0]       fifo_rd_data,
  output logic              fifo_empty,
  output logic [CNT_W-1:0]  fifo_count
);
  localparam int DEPTH = NUM_CH + 1;

  logic              trig, push, scan_done;
  result_t           push_data;
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic              temp_q, temp_d;
  logic              ovr_q, ovr_d;
  logic              eoc_q, eoc_d;

  start_detect #(.MIN_LOW(MIN_LOW)) u_start (
    .clk(clk), .rst_n(rst_n), .cnvst_n(cnvst_n), .trig(trig)
  );

  seq_fsm #(.NUM_CH(NUM_CH), .WAKE_CYC(WAKE_CYC), .ACQ_CYC(ACQ_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig(trig), .mask(mask_q), .temp_en(temp_q),
    .adc_done(adc_done), .adc_data(adc_data), .adc_start(adc_start),
    .adc_chan(adc_chan), .busy(busy), .push(push), .push_data(push_data),
    .scan_done(scan_done)
  );

  result_fifo #(.DEPTH(DEPTH), .W(16)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .rd_data(fifo_rd_data), .empty(fifo_empty), .count(fifo_count)
  );

  always_comb begin
    mask_d = mask_q;
    temp_d = temp_q;
    ovr_d  = ovr_q;
    eoc_d  = eoc_q;
    if (reg_we && !busy && reg_addr == 2'd0) mask_d = reg_wdata;
    if (reg_we && !busy && reg_addr == 2'd1) temp_d = reg_wdata[0];
    if (reg_we && reg_addr == 2'd2)          ovr_d  = 1'b0;
    if (trig && busy)                        ovr_d  = 1'b1;
    if (!cs_n || !cnvst_n)                   eoc_d  = 1'b1;
    if (scan_done)                           eoc_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      temp_q <= 1'b0;
      ovr_q  <= 1'b0;
      eoc_q  <= 1'b1;
    end else begin
      mask_q <= mask_d;
      temp_q <= temp_d;
      ovr_q  <= ovr_d;
      eoc_q  <= eoc_d;
    end
  end

  assign adc_pwr = busy;
  assign eoc_n   = eoc_q;
  assign overrun = ovr_q;

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy) |=> overrun);
  // R5
  eoc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n |-> !busy);
  // R7
  mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mask_q));
endmodule

// File: tb/scan_sequencer_test.sv
module scan_sequencer_test;
  localparam int NUM_CH = 8, MIN_LOW = 5, WAKE_CYC = 4, ACQ_CYC = 3;
  localparam int CNT_W = $clog2(NUM_CH + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnvst_n = 1'b1, cs_n = 1'b1, reg_we = 1'b0, pop = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [NUM_CH-1:0] reg_wdata = '0;
  logic adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic adc_start, adc_pwr, busy, eoc_n, overrun, fifo_empty;
  logic [3:0] adc_chan;
  logic [15:0] fifo_rd_data;
  logic [CNT_W-1:0] fifo_count;

  int n_chk = 0, n_bad = 0;

  scan_sequencer #(.NUM_CH(NUM_CH), .MIN_LOW(MIN_LOW), .WAKE_CYC(WAKE_CYC),
                   .ACQ_CYC(ACQ_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .cnvst_n(cnvst_n), .cs_n(cs_n), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .adc_start(adc_start),
    .adc_chan(adc_chan), .adc_pwr(adc_pwr), .adc_done(adc_done),
    .adc_data(adc_data), .busy(busy), .eoc_n(eoc_n), .overrun(overrun),
    .pop(pop), .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
    .fifo_count(fifo_count)
  );

  always #4 clk = ~clk;

  function automatic logic [11:0] conv_val(input logic [3:0] id);
    return 12'h300 + 12'(id) * 12'd7;
  endfunction

  // converter model: answers each start strobe two cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (adc_start) begin
        logic [3:0] ch;
        ch = adc_chan;
        repeat (2) @(negedge clk);
        adc_data = conv_val(ch);
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = NUM_CH'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_start(input int n);
    @(negedge clk);
    cnvst_n = 1'b0;
    repeat (n) @(negedge clk);
    cnvst_n = 1'b1;
  endtask

  task automatic wait_eoc(input string tag);
    int k = 0;
    while (eoc_n && k < 1000) begin @(negedge clk); k++; end
    check({tag, " eoc low"}, int'(eoc_n), 0);
  endtask

  // drain queue and compare with expected ids
  task automatic drain(input string tag, input int ids[$]);
    check({tag, " count"}, int'(fifo_count), ids.size());
    foreach (ids[i]) begin
      @(negedge clk);
      check({tag, " entry"}, int'(fifo_rd_data),
            int'({4'(ids[i]), conv_val(4'(ids[i]))}));
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
    end
    @(negedge clk);
    check({tag, " empty"}, int'(fifo_empty), 1);
  endtask

  task automatic clear_eoc();
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic test_reset();
    check("R8 eoc_n", int'(eoc_n), 1);
    check("R8 busy", int'(busy), 0);
    check("R8 adc_pwr", int'(adc_pwr), 0);
    check("R8 overrun", int'(overrun), 0);
    check("R8 empty", int'(fifo_empty), 1);
    check("R8 count", int'(fifo_count), 0);
  endtask

  task automatic test_short_pulse();
    write_reg(2'd0, 8'h01);
    pulse_start(MIN_LOW - 1);
    repeat (20) begin
      @(negedge clk);
      if (busy) break;
    end
    check("R1 short pulse busy", int'(busy), 0);
    check("R1 short pulse queue", int'(fifo_count), 0);
    check("R1 short pulse eoc", int'(eoc_n), 1);
  endtask

  task automatic test_timing_order();
    int k = 0;
    write_reg(2'd0, 8'hA5);
    pulse_start(MIN_LOW);
    while (!adc_start && k < 100) begin @(negedge clk); k++; end
    check("R2 first strobe offset", k, WAKE_CYC + ACQ_CYC);
    check("R2 power during scan", int'(adc_pwr), 1);
    wait_eoc("R2");
    check("R2 power after scan", int'(adc_pwr), 0);
    check("R2 busy after scan", int'(busy), 0);
    drain("R3 mask a5", '{0, 2, 5, 7});
    check("R5 eoc held after pops", int'(eoc_n), 0);
    clear_eoc();
    check("R5 cs clears eoc", int'(eoc_n), 1);
  endtask

  task automatic test_temp_first();
    write_reg(2'd0, 8'h42);
    write_reg(2'd1, 1);
    pulse_start(MIN_LOW + 2);
    wait_eoc("R4");
    drain("R4 temp first", '{15, 1, 6});
    write_reg(2'd1, 0);
    // cnvst_n low below threshold clears eoc without starting a scan
    pulse_start(1);
    @(negedge clk);
    check("R5 cnvst clears eoc", int'(eoc_n), 1);
    check("R1 no scan from clear pulse", int'(busy), 0);
  endtask

  task automatic test_overrun();
    write_reg(2'd0, 8'h0E);
    pulse_start(MIN_LOW);
    @(negedge clk);
    check("R6 busy", int'(busy), 1);
    pulse_start(MIN_LOW);
    @(negedge clk);
    check("R6 overrun set", int'(overrun), 1);
    wait_eoc("R6");
    drain("R6 scan undisturbed", '{1, 2, 3});
    check("R6 overrun sticky", int'(overrun), 1);
    clear_eoc();
    pulse_start(MIN_LOW);
    @(negedge clk);
    write_reg(2'd2, 0);
    check("R6 clear while busy", int'(busy), 1);
    check("R6 overrun cleared", int'(overrun), 0);
    wait_eoc("R6b");
    drain("R6 second scan", '{1, 2, 3});
    clear_eoc();
  endtask

  task automatic test_busy_write();
    write_reg(2'd0, 8'h81);
    pulse_start(MIN_LOW);
    @(negedge clk);
    write_reg(2'd0, 8'h10);
    write_reg(2'd1, 1);
    wait_eoc("R7");
    drain("R7 scan keeps mask", '{0, 7});
    clear_eoc();
    pulse_start(MIN_LOW);
    wait_eoc("R7b");
    drain("R7 next scan keeps mask", '{0, 7});
    clear_eoc();
  endtask

  task automatic test_empty_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    check("R9 pop on empty count", int'(fifo_count), 0);
    write_reg(2'd0, 8'h08);
    pulse_start(MIN_LOW);
    wait_eoc("R9");
    check("R9 fall-through head", int'(fifo_rd_data), int'({4'd3, conv_val(4'd3)}));
    drain("R9 single", '{3});
    clear_eoc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_short_pulse();
    test_timing_order();
    test_temp_first();
    test_overrun();
    test_busy_write();
    test_empty_pop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule